// File: doc/BRIEF.md
# GPIO Function Mux with Lock Interrupt

This block controls a small group of general-purpose pins. Every pin has a configuration word. Its 4-bit function select picks what the pin drives: a constant low, a constant high, or the synchronized PLL lock indication. Global gating decides whether a pin may drive at all. The gating comes from a dedicated enable for the first pin, an audio-interface select that claims pins 3 to 5, a global tristate bit, and the pin's own pull controls. A pin that may not drive, or whose select code is not one of the three functions, has its output enable low and its data low.

The lock input is asynchronous. It passes through a two-flop synchronizer before it feeds either the pins or the interrupt logic. The interrupt side applies a programmable polarity to the synchronized lock. A rising edge of that adjusted signal sets a sticky flag. The flag is cleared by writing 1 to it. The interrupt line is the flag gated by an enable bit. Software can read both the flag and the live adjusted lock level at any time. The polarity bit never changes what a pin drives.

Software reaches the block through a simple register port: a write strobe with address and data, and a combinational read address. Register map: address 0 is control, address k (1..N) is the config word of pin k (vector bit k-1), and address 7 is status.

Top module: `gpio_lock_ctrl`

## Requirements
- R1: After reset every register reads 0, all pin output enables and pull outputs are 0, and irq is 0.
- R2: Pin config bits [3:0] select the function. 4'b0010 drives 0 and 4'b0011 drives 1, with output enable 1 when the pin is permitted to drive.
- R3: Select 4'b0100 drives the synchronized lock level, 1 when locked. A change on the lock input shows on the pin after the second rising clock edge, and the polarity bit never inverts it.
- R4: Any other select code gives output enable 0 and data 0.
- R5: Pin 1 (vector bit 0) drives only when control bit 0 is 1.
- R6: Pins 3 to 5 (vector bits 2 to 4) drive only when control bit 1 is 0. Other pins ignore that bit.
- R7: Control bit 2 set to 1 forces every output enable to 0.
- R8: Pin config bit 4 (pull-up) and bit 5 (pull-down) appear on pin_pu and pin_pd. Either one set forces that pin's output enable to 0.
- R9: Control bit 3 inverts the lock seen by the interrupt logic. A rising edge of the adjusted, synchronized lock sets status bit 0 one edge later, which is three edges after the input changes.
- R10: irq equals status bit 0 ANDed with control bit 4. With that enable at 0, irq stays 0 even when the flag is set.
- R11: Writing status with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it set. The flag holds until it is cleared.
- R12: Status bit 1 always reads the live adjusted lock level, whatever the enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| pll_lock_async | input | 1 | Asynchronous PLL lock indication |
| pin_out | output | 5 | Per-pin data |
| pin_oe | output | 5 | Per-pin output enable |
| pin_pu | output | 5 | Per-pin pull-up control |
| pin_pd | output | 5 | Per-pin pull-down control |
| irq | output | 1 | Lock interrupt |

## Verification
A register write takes effect at the clock edge that samples it, so pin enables, pulls and irq are checked one time step after that edge. A lock input change reaches the pins and status bit 1 after exactly two edges. It reaches the flag and irq after three edges. The directed tests sample after the first and second edges to show the value has not arrived early. The table loop waits three edges after each stimulus, so every path has settled before the check.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_LOW  = 4'b0010;
  localparam logic [SEL_W-1:0] SEL_HIGH = 4'b0011;
  localparam logic [SEL_W-1:0] SEL_LOCK = 4'b0100;

  typedef struct packed {
    logic             pd;
    logic             pu;
    logic [SEL_W-1:0] sel;
  } pin_cfg_t;

  typedef struct packed {
    logic irq_en;
    logic lock_pol;
    logic tris_all;
    logic aif_claim;
    logic pin1_en;
  } ctrl_t;

  localparam int CFG_W  = $bits(pin_cfg_t);
  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic sel_known(input logic [SEL_W-1:0] s);
    return (s == SEL_LOW) || (s == SEL_HIGH) || (s == SEL_LOCK);
  endfunction

  function automatic logic sel_level(input logic [SEL_W-1:0] s, input logic lock);
    case (s)
      SEL_HIGH: return 1'b1;
      SEL_LOCK: return lock;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic pin_permitted(input int idx, input int aif_lo, input int aif_hi,
                                         input ctrl_t c, input pin_cfg_t p);
    logic ok;
    ok = !c.tris_all && !p.pu && !p.pd;
    if (idx == 0) ok = ok && c.pin1_en;
    if (idx >= aif_lo && idx <= aif_hi) ok = ok && !c.aif_claim;
    return ok;
  endfunction
endpackage

// File: rtl/gpio_lock_sync.sv
module gpio_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_lock_irq.sv
module gpio_lock_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_sync,
  input  logic lock_pol,
  input  logic irq_en,
  input  logic flag_clr,
  output logic lock_adj,
  output logic lock_rise,
  output logic irq_flag,
  output logic irq
);
  logic adj_q;

  assign lock_adj  = lock_sync ^ lock_pol;
  assign lock_rise = lock_adj & ~adj_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_q    <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      adj_q <= lock_adj;
      if (lock_rise)     irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end

  assign irq = irq_flag & irq_en;
endmodule

// File: rtl/gpio_lock_regs.sv
module gpio_lock_regs
  import gpio_lock_pkg::*;
#(
  parameter int N         = 5,
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int STAT_ADDR = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  input  logic [1:0]           status,
  output logic [DW-1:0]        rd_data,
  output ctrl_t                ctrl,
  output pin_cfg_t [N-1:0]     cfg,
  output logic                 flag_clr
);
  localparam logic [AW-1:0] CTRL_A = '0;
  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      cfg  <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_A) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
      for (int i = 0; i < N; i++)
        if (wr_addr == AW'(i + 1)) cfg[i] <= pin_cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  assign flag_clr = wr_en && (wr_addr == STAT_A) && wr_data[0];

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_A) rd_data = DW'(ctrl);
    if (rd_addr == STAT_A) rd_data = DW'(status);
    for (int i = 0; i < N; i++)
      if (rd_addr == AW'(i + 1)) rd_data = DW'(cfg[i]);
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_lock_pkg::*;
#(
  parameter int PIN_IDX = 0,
  parameter int AIF_LO  = 2,
  parameter int AIF_HI  = 4
) (
  input  ctrl_t    ctrl,
  input  pin_cfg_t cfg,
  input  logic     lock_sync,
  output logic     out,
  output logic     oe,
  output logic     pu,
  output logic     pd
);
  logic drive;

  assign drive = sel_known(cfg.sel) && pin_permitted(PIN_IDX, AIF_LO, AIF_HI, ctrl, cfg);
  assign oe    = drive;
  assign out   = drive && sel_level(cfg.sel, lock_sync);
  assign pu    = cfg.pu;
  assign pd    = cfg.pd;
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_lock_pkg::*;
#(
  parameter int N         = 5,
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int STAT_ADDR = 7,
  parameter int SYNC_STG  = 2,
  parameter int AIF_LO    = 2,
  parameter int AIF_HI    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          pll_lock_async,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  pin_pu,
  output logic [N-1:0]  pin_pd,
  output logic          irq
);
  ctrl_t            ctrl;
  pin_cfg_t [N-1:0] cfg;
  logic             lock_sync;
  logic             lock_adj;
  logic             lock_rise;
  logic             irq_flag;
  logic             flag_clr;
  logic             tris_all;
  logic             irq_en;

  assign tris_all = ctrl.tris_all;
  assign irq_en   = ctrl.irq_en;

  gpio_lock_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pll_lock_async), .q_sync(lock_sync)
  );

  gpio_lock_regs #(.N(N), .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .status({lock_adj, irq_flag}), .rd_data(rd_data),
    .ctrl(ctrl), .cfg(cfg), .flag_clr(flag_clr)
  );

  gpio_lock_irq u_irq (
    .clk(clk), .rst_n(rst_n), .lock_sync(lock_sync), .lock_pol(ctrl.lock_pol),
    .irq_en(irq_en), .flag_clr(flag_clr), .lock_adj(lock_adj),
    .lock_rise(lock_rise), .irq_flag(irq_flag), .irq(irq)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    gpio_pin_mux #(.PIN_IDX(i), .AIF_LO(AIF_LO), .AIF_HI(AIF_HI)) u_mux (
      .ctrl(ctrl), .cfg(cfg[i]), .lock_sync(lock_sync),
      .out(pin_out[i]), .oe(pin_oe[i]), .pu(pin_pu[i]), .pd(pin_pd[i])
    );
  end
endmodule

// File: rtl/gpio_lock_ctrl_chk.sv
module gpio_lock_ctrl_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pin_oe,
  input logic [N-1:0] pin_pu,
  input logic [N-1:0] pin_pd,
  input logic         irq,
  input logic         tris_all,
  input logic         irq_en,
  input logic         lock_rise,
  input logic         irq_flag,
  input logic         flag_clr
);
  a_r7_tris_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    tris_all |-> (pin_oe == '0));

  a_r8_pull_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu | pin_pd) & pin_oe) == '0);

  a_r9_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rise |=> irq_flag);

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r11_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !lock_rise) |=> !irq_flag);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);
endmodule

bind gpio_lock_ctrl gpio_lock_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_pd(pin_pd),
  .irq(irq), .tris_all(tris_all), .irq_en(irq_en), .lock_rise(lock_rise),
  .irq_flag(irq_flag), .flag_clr(flag_clr)
);

// File: tb/tb_gpio_lock_ctrl.sv
module tb_gpio_lock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic lock = 1'b0;
  logic [N-1:0] pin_out, pin_oe, pin_pu, pin_pd;
  logic irq;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pll_lock_async(lock),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_pd(pin_pd), .irq(irq)
  );

  // {req[3:0], ctrl[7:0], cfg[7:0], idx[2:0], lock, exp_oe, exp_out}
  localparam logic [25:0] VEC [NV] = '{
    {4'd2, 8'h00, 8'h02, 3'd1, 1'b0, 1'b1, 1'b0},
    {4'd2, 8'h00, 8'h03, 3'd1, 1'b0, 1'b1, 1'b1},
    {4'd3, 8'h00, 8'h04, 3'd1, 1'b1, 1'b1, 1'b1},
    {4'd3, 8'h08, 8'h04, 3'd1, 1'b1, 1'b1, 1'b1},
    {4'd3, 8'h08, 8'h04, 3'd1, 1'b0, 1'b1, 1'b0},
    {4'd4, 8'h00, 8'h05, 3'd1, 1'b0, 1'b0, 1'b0},
    {4'd4, 8'h00, 8'h0F, 3'd1, 1'b1, 1'b0, 1'b0},
    {4'd4, 8'h00, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0},
    {4'd4, 8'h00, 8'h01, 3'd1, 1'b1, 1'b0, 1'b0},
    {4'd5, 8'h00, 8'h03, 3'd0, 1'b0, 1'b0, 1'b0},
    {4'd5, 8'h01, 8'h03, 3'd0, 1'b0, 1'b1, 1'b1},
    {4'd6, 8'h02, 8'h03, 3'd2, 1'b0, 1'b0, 1'b0},
    {4'd6, 8'h02, 8'h03, 3'd4, 1'b0, 1'b0, 1'b0},
    {4'd6, 8'h00, 8'h03, 3'd3, 1'b0, 1'b1, 1'b1},
    {4'd6, 8'h02, 8'h03, 3'd1, 1'b0, 1'b1, 1'b1},
    {4'd6, 8'h03, 8'h04, 3'd0, 1'b1, 1'b1, 1'b1},
    {4'd7, 8'h04, 8'h03, 3'd1, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'h05, 8'h03, 3'd0, 1'b0, 1'b0, 1'b0},
    {4'd8, 8'h00, 8'h13, 3'd1, 1'b0, 1'b0, 1'b0},
    {4'd8, 8'h00, 8'h23, 3'd1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lock = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    do_reset();
    // R1 reset state
    check("R1 oe", 8'(pin_oe), 8'h00);
    check("R1 pulls", 8'(pin_pu | pin_pd), 8'h00);
    check("R1 irq", 8'(irq), 8'h00);
    rd(3'd0, r); check("R1 ctrl", r, 8'h00);
    rd(3'd1, r); check("R1 cfg", r, 8'h00);
    rd(3'd7, r); check("R1 status", r, 8'h00);

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [25:0] e;
      int idx;
      e = VEC[v];
      idx = int'(e[5:3]);
      wr(3'd0, e[21:14]);
      wr(3'(idx + 1), e[13:6]);
      lock = e[2];
      repeat (3) tick();
      check($sformatf("R%0d oe vec%0d", e[25:22], v), 8'(pin_oe[idx]), 8'(e[1]));
      check($sformatf("R%0d out vec%0d", e[25:22], v), 8'(pin_out[idx]), 8'(e[0]));
    end

    // Directed: lock timing, interrupt path
    do_reset();
    wr(3'd2, 8'h04);
    lock = 1'b1;
    tick();
    check("R3 one edge early", 8'(pin_out[1]), 8'h00);
    rd(3'd7, r); check("R12 status early", r, 8'h00);
    tick();
    check("R3 two edges", 8'(pin_out[1]), 8'h01);
    rd(3'd7, r); check("R12 live level", r, 8'h02);
    tick();
    rd(3'd7, r); check("R9 flag set", r, 8'h03);
    check("R10 masked irq", 8'(irq), 8'h00);
    wr(3'd0, 8'h10);
    check("R10 enabled irq", 8'(irq), 8'h01);
    wr(3'd7, 8'h00);
    rd(3'd7, r); check("R11 write0 keeps", r, 8'h03);
    wr(3'd7, 8'h01);
    rd(3'd7, r); check("R11 write1 clears", r, 8'h02);
    check("R11 irq low", 8'(irq), 8'h00);
    wr(3'd0, 8'h18);
    rd(3'd7, r); check("R12 inverted level", r, 8'h00);
    check("R3 pol no effect", 8'(pin_out[1]), 8'h01);
    lock = 1'b0;
    repeat (2) tick();
    rd(3'd7, r); check("R9 inverted before flag", r, 8'h02);
    tick();
    rd(3'd7, r); check("R9 inverted flag", r, 8'h03);
    check("R10 irq on", 8'(irq), 8'h01);
    wr(3'd2, 8'h13);
    check("R8 pu out", 8'(pin_pu[1]), 8'h01);
    check("R8 pu blocks oe", 8'(pin_oe[1]), 8'h00);
    wr(3'd2, 8'h23);
    check("R8 pd out", 8'(pin_pd[1]), 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule